// File: doc/BRIEF.md
# Flash Control/Status Port with Erase Sequencer

This block is the control-side register port of an on-chip flash. Behind a one-bit address it holds two 32-bit words. The word at offset 0 is a read-only status word. It reports what the flash is doing, whether the last read, program and erase succeeded, and which sectors are locked against access. The word at offset 1 is the control word. It carries the per-sector write-protect bits and the two fields that start an erase: a sector code and a page address.

Writing a control word while the flash is idle starts an erase. A sector code other than the not-set value `111` starts a sector erase, and the page field is then ignored. A page address other than all ones starts a page erase. Either field returns to its not-set value once the erase has been launched. Illegal or protected targets are rejected: the block passes through the erasing state for one cycle, never contacts the array, and records a failure.

A legal erase is handed to the array with a level request that is held until the array reports done. A cycle counter caps the wait at `ERASE_MAX_CYC` cycles and records a failure if done never arrives. While any erase is in progress, new commands on the data port are stalled.

Top module: `flash_csr_seq`

## Requirements
- R1: After reset, status reads `{22 ones, SEC_HIDE, 3'b000, 2'b00}` and control reads `32'hFFFF_FFFF` (all write-protect bits set, sector field `111`, page field all ones).
- R2: Status layout. Bits [1:0] give the state: `00` idle, `01` erasing, `10` programming, `11` reading. Bit 2 is read-ok, bit 3 is program-ok and bit 4 is erase-ok. Bits [9:5] are the lock flags `SEC_HIDE`, with bit 5+i belonging to sector code i+1. Bits [31:10] read 1. When the data path is both programming and reading, `10` is shown. A read returns its word one cycle after `csr_rd`.
- R3: A control read returns the stored write-protect bits in [27:23] (bit 23+i protects sector code i+1), `111` in [22:20], all ones in [19:0], and ones in [31:28].
- R4: A write to offset 0 changes nothing and starts nothing.
- R5: In idle, a control write with a legal sector code (`001`..`101`) whose sector is neither write-protected nor locked raises `arr_erase_req` in the next cycle, with `arr_erase_sector_mode`=1 and `arr_erase_sector` set to the code. Status reads `01` while the request is up. After `arr_erase_done` the status returns to idle with erase-ok=1.
- R6: In idle, a control write with sector code `111` and a page address other than all ones starts a page erase of that page (`arr_erase_sector_mode`=0). A write with both fields not-set starts nothing and leaves erase-ok unchanged.
- R7: When one write carries both a sector code other than `111` and a page address, the sector erase runs.
- R8: A control write is not accepted as an erase start while the status state is anything but `00`. Its write-protect bits are still stored.
- R9: An illegal sector code (`000`, `110`) raises no array request and leaves erase-ok at 0.
- R10: A target whose sector is protected (by the write-protect bits in the same write, or by `SEC_HIDE`) is rejected with erase-ok=0 and no array request. So is a page at or above the last map bound. Page p belongs to the lowest sector i with p < `PAGE_BOUND[20*i +: 20]`.
- R11: While an erase is in progress, `dp_waitreq` follows `dp_cmd`. In idle it stays 0.
- R12: If `arr_erase_done` does not arrive, `arr_erase_req` stays up for exactly `ERASE_MAX_CYC` cycles, then drops, and erase-ok reads 0.
- R13: A `dp_rd_done` pulse copies `dp_rd_ok` into status bit 2. A `dp_wr_done` pulse copies `dp_wr_ok` into bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 1 | Register select: 0 status, 1 control |
| csr_rd | input | 1 | Register read strobe |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid the cycle after `csr_rd` |
| dp_cmd | input | 1 | A new command is presented on the data port |
| dp_waitreq | output | 1 | Stall for that data-port command |
| dp_rd_active | input | 1 | Data path is reading |
| dp_wr_active | input | 1 | Data path is programming |
| dp_rd_done | input | 1 | Read result pulse |
| dp_rd_ok | input | 1 | Read result, 1 = success |
| dp_wr_done | input | 1 | Program result pulse |
| dp_wr_ok | input | 1 | Program result, 1 = success |
| arr_erase_req | output | 1 | Erase request to the array, held until done |
| arr_erase_sector_mode | output | 1 | 1 = sector erase, 0 = page erase |
| arr_erase_sector | output | 3 | Sector code of a sector erase |
| arr_erase_page | output | 20 | Page address of a page erase |
| arr_erase_done | input | 1 | Array reports that the erase is finished |

## Verification
The hardest cases to reach are the ones where a control write lands while the block is not idle. One is a write during a running erase, and the other is a write while the data path reports activity. In both cases the start must be refused, yet the write-protect bits must still be taken. The bench reaches them by launching an erase and withholding `arr_erase_done`, then issuing a second control write with a different sector code and different protect bits. It also holds `dp_wr_active` high before a control write. It then checks at the ports that the array target is unchanged, that no request appears, and that the control readback shows the new protect bits. The timeout is reached the same way, by never answering the request, with the limit shrunk through the parameter.

// File: rtl/flash_csr_seq.sv
module flash_csr_seq #(
  parameter int unsigned ERASE_MAX_CYC = 17_500_000,
  parameter logic [4:0]  SEC_HIDE      = 5'b00000,
  parameter logic [99:0] PAGE_BOUND    = {20'd80, 20'd64, 20'd48, 20'd32, 20'd16}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_addr,
  input  logic        csr_rd,
  input  logic        csr_wr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        dp_cmd,
  output logic        dp_waitreq,
  input  logic        dp_rd_active,
  input  logic        dp_wr_active,
  input  logic        dp_rd_done,
  input  logic        dp_rd_ok,
  input  logic        dp_wr_done,
  input  logic        dp_wr_ok,
  output logic        arr_erase_req,
  output logic        arr_erase_sector_mode,
  output logic [2:0]  arr_erase_sector,
  output logic [19:0] arr_erase_page,
  input  logic        arr_erase_done
);
  localparam int unsigned NSEC  = 5;
  localparam int unsigned PW    = 20;
  localparam int unsigned CNT_W = $clog2(ERASE_MAX_CYC + 1);
  localparam logic [2:0]  NOSEC = 3'b111;
  localparam logic [PW-1:0] NOPAGE = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ERASE_MAX_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FAIL} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [NSEC-1:0]  wp_q;
  logic             rd_ok_q, wr_ok_q, er_ok_q;
  logic             tgt_mode_q;
  logic [2:0]       tgt_sec_q;
  logic [PW-1:0]    tgt_page_q;

  logic [1:0]      busy;
  logic            wr_ctl, sec_req, pg_req, sec_legal, launch, good;
  logic [2:0]      w_sec, sec_idx, pg_idx;
  logic [PW-1:0]   w_page;
  logic [NSEC-1:0] w_wp;
  logic [7:0]      lock8;
  logic            pg_hit;
  logic [31:0]     stat_word, ctrl_word;

  assign busy = (st != ST_IDLE) ? 2'b01 :
                dp_wr_active    ? 2'b10 :
                dp_rd_active    ? 2'b11 : 2'b00;

  assign wr_ctl    = csr_wr && csr_addr;
  assign w_sec     = csr_wdata[22:20];
  assign w_page    = csr_wdata[19:0];
  assign w_wp      = csr_wdata[27:23];
  assign sec_req   = (w_sec != NOSEC);
  assign pg_req    = !sec_req && (w_page != NOPAGE);
  assign sec_legal = (w_sec >= 3'd1) && (w_sec <= 3'd5);
  assign sec_idx   = w_sec - 3'd1;
  assign lock8     = {3'b111, w_wp | SEC_HIDE};

  always_comb begin
    pg_hit = 1'b0;
    pg_idx = 3'd0;
    for (int i = 0; i < NSEC; i++) begin
      if (!pg_hit && (w_page < PAGE_BOUND[PW*i +: PW])) begin
        pg_hit = 1'b1;
        pg_idx = 3'(i);
      end
    end
  end

  assign launch = wr_ctl && (busy == 2'b00) && (sec_req || pg_req);
  assign good   = sec_req ? (sec_legal && !lock8[sec_idx]) : (pg_hit && !lock8[pg_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      er_ok_q    <= 1'b0;
      tgt_mode_q <= 1'b0;
      tgt_sec_q  <= NOSEC;
      tgt_page_q <= NOPAGE;
    end else begin
      case (st)
        ST_IDLE: if (launch) begin
          st         <= good ? ST_RUN : ST_FAIL;
          cnt        <= '0;
          er_ok_q    <= 1'b0;
          tgt_mode_q <= sec_req;
          tgt_sec_q  <= sec_req ? w_sec : NOSEC;
          tgt_page_q <= sec_req ? NOPAGE : w_page;
        end
        ST_RUN: begin
          if (arr_erase_done) begin
            st      <= ST_IDLE;
            er_ok_q <= 1'b1;
          end else if (cnt == CNT_LAST) begin
            st      <= ST_IDLE;
            er_ok_q <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '1;
      rd_ok_q <= 1'b0;
      wr_ok_q <= 1'b0;
    end else begin
      if (wr_ctl)     wp_q    <= w_wp;
      if (dp_rd_done) rd_ok_q <= dp_rd_ok;
      if (dp_wr_done) wr_ok_q <= dp_wr_ok;
    end
  end

  assign stat_word = {22'h3F_FFFF, SEC_HIDE, er_ok_q, wr_ok_q, rd_ok_q, busy};
  assign ctrl_word = {4'hF, wp_q, NOSEC, NOPAGE};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csr_rdata <= '0;
    else if (csr_rd) csr_rdata <= csr_addr ? ctrl_word : stat_word;
  end

  assign arr_erase_req         = (st == ST_RUN);
  assign arr_erase_sector_mode = tgt_mode_q;
  assign arr_erase_sector      = tgt_sec_q;
  assign arr_erase_page        = tgt_page_q;
  assign dp_waitreq            = (st != ST_IDLE) && dp_cmd;
endmodule

// File: rtl/flash_csr_seq_chk.sv
module flash_csr_seq_chk #(
  parameter int unsigned ERASE_MAX_CYC = 17_500_000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_addr,
  input logic        csr_rd,
  input logic        csr_wr,
  input logic [31:0] csr_rdata,
  input logic        dp_cmd,
  input logic        dp_waitreq,
  input logic        arr_erase_req,
  input logic        arr_erase_done
);
  int unsigned req_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             req_cyc <= 0;
    else if (arr_erase_req) req_cyc <= req_cyc + 1;
    else                    req_cyc <= 0;
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase_req && !arr_erase_done && (req_cyc + 1 < ERASE_MAX_CYC) |=> arr_erase_req);

  assert_req_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase_req && arr_erase_done |=> !arr_erase_req);

  assert_start_by_ctl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_erase_req) |-> $past(csr_wr && csr_addr));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase_req && dp_cmd |-> dp_waitreq);

  assert_no_stall_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_cmd |-> !dp_waitreq);

  assert_pad_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd |=> (&csr_rdata[31:28]));

  assert_timeout_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase_req |-> (req_cyc < ERASE_MAX_CYC));
endmodule

bind flash_csr_seq flash_csr_seq_chk #(.ERASE_MAX_CYC(ERASE_MAX_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
  .csr_rdata(csr_rdata), .dp_cmd(dp_cmd), .dp_waitreq(dp_waitreq),
  .arr_erase_req(arr_erase_req), .arr_erase_done(arr_erase_done)
);

// File: tb/test_flash_csr_seq.sv
module test_flash_csr_seq;
  localparam int unsigned MAXC = 40;
  localparam logic [4:0]  HIDE = 5'b10000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_addr = 1'b0, csr_rd = 1'b0, csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        dp_cmd = 1'b0, dp_waitreq;
  logic        dp_rd_active = 1'b0, dp_wr_active = 1'b0;
  logic        dp_rd_done = 1'b0, dp_rd_ok = 1'b0, dp_wr_done = 1'b0, dp_wr_ok = 1'b0;
  logic        arr_erase_req, arr_erase_sector_mode;
  logic [2:0]  arr_erase_sector;
  logic [19:0] arr_erase_page;
  logic        arr_erase_done = 1'b0;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_csr_seq #(.ERASE_MAX_CYC(MAXC), .SEC_HIDE(HIDE)) i_flash_csr_seq (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dp_cmd(dp_cmd), .dp_waitreq(dp_waitreq),
    .dp_rd_active(dp_rd_active), .dp_wr_active(dp_wr_active), .dp_rd_done(dp_rd_done),
    .dp_rd_ok(dp_rd_ok), .dp_wr_done(dp_wr_done), .dp_wr_ok(dp_wr_ok),
    .arr_erase_req(arr_erase_req), .arr_erase_sector_mode(arr_erase_sector_mode),
    .arr_erase_sector(arr_erase_sector), .arr_erase_page(arr_erase_page),
    .arr_erase_done(arr_erase_done)
  );

  // {wdata, launch, sector_mode, erase_ok, target}
  localparam logic [54:0] VEC [12] = '{
    {4'hF, 5'b00000, 3'd3, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 20'd3},  // R5 sector erase
    {4'hF, 5'b00000, 3'd0, 20'hFFFFF, 1'b0, 1'b0, 1'b0, 20'd0},  // R9 code 000
    {4'hF, 5'b00000, 3'd7, 20'd20,    1'b1, 1'b0, 1'b1, 20'd20}, // R6 page erase
    {4'hF, 5'b00000, 3'd6, 20'hFFFFF, 1'b0, 1'b0, 1'b0, 20'd0},  // R9 code 110
    {4'hF, 5'b00010, 3'd2, 20'hFFFFF, 1'b0, 1'b0, 1'b0, 20'd0},  // R10 wp sector 2
    {4'hF, 5'b00000, 3'd1, 20'd5,     1'b1, 1'b1, 1'b1, 20'd1},  // R7 sector wins
    {4'hF, 5'b00000, 3'd5, 20'hFFFFF, 1'b0, 1'b0, 1'b0, 20'd0},  // R10 locked sector 5
    {4'hF, 5'b00000, 3'd7, 20'd70,    1'b0, 1'b0, 1'b0, 20'd0},  // R10 page in locked sector
    {4'hF, 5'b00000, 3'd7, 20'd90,    1'b0, 1'b0, 1'b0, 20'd0},  // R10 page outside map
    {4'hF, 5'b00100, 3'd7, 20'd40,    1'b0, 1'b0, 1'b0, 20'd0},  // R10 page in wp sector 3
    {4'hF, 5'b00000, 3'd7, 20'd0,     1'b1, 1'b0, 1'b1, 20'd0},  // R6 page 0
    {4'hF, 5'b00000, 3'd7, 20'hFFFFF, 1'b0, 1'b0, 1'b1, 20'd0}   // R6 nothing set, ok kept
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic a, input logic [31:0] d);
    @(negedge clk); csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk); csr_wr = 1'b0;
  endtask

  task automatic csr_read(input logic a, output logic [31:0] d);
    @(negedge clk); csr_addr = a; csr_rd = 1'b1;
    @(negedge clk); csr_rd = 1'b0; d = csr_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); arr_erase_done = 1'b1;
    @(negedge clk); arr_erase_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, exp_stat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_stat = {22'h3FFFFF, HIDE, 5'b00000};
    csr_read(1'b0, rd); chk(rd == exp_stat, "R1 R2 status reset", rd, exp_stat);
    csr_read(1'b1, rd); chk(rd == 32'hFFFFFFFF, "R1 R3 ctrl reset", rd, 32'hFFFFFFFF);

    for (int v = 0; v < 12; v++) begin
      logic [54:0] e;
      e = VEC[v];
      csr_write(1'b1, e[54:23]);
      chk(arr_erase_req == e[22], $sformatf("R5-vec%0d launch", v), {31'b0, arr_erase_req}, {31'b0, e[22]});
      if (e[22]) begin
        chk(arr_erase_sector_mode == e[21], $sformatf("R7 vec%0d mode", v),
            {31'b0, arr_erase_sector_mode}, {31'b0, e[21]});
        if (e[21]) chk(arr_erase_sector == e[2:0], $sformatf("R5 vec%0d sector", v),
                       {29'b0, arr_erase_sector}, {29'b0, e[2:0]});
        else       chk(arr_erase_page == e[19:0], $sformatf("R6 vec%0d page", v),
                       {12'b0, arr_erase_page}, {12'b0, e[19:0]});
        pulse_done();
      end else begin
        repeat (2) @(negedge clk);
      end
      csr_read(1'b0, rd);
      chk(rd[4] == e[20] && rd[1:0] == 2'b00, $sformatf("R9 R10 vec%0d erase_ok", v),
          {27'b0, rd[4:0]}, {27'b0, e[20], 4'b0});
    end

    // R8 and R11: write during a running erase, stall on the data port
    csr_write(1'b1, {4'hF, 5'b00000, 3'd3, 20'hFFFFF});
    dp_cmd = 1'b1;
    @(negedge clk);
    chk(dp_waitreq == 1'b1, "R11 stall in erase", {31'b0, dp_waitreq}, 32'd1);
    csr_read(1'b0, rd);
    chk(rd[1:0] == 2'b01, "R5 busy erasing", {30'b0, rd[1:0]}, 32'd1);
    csr_write(1'b1, {4'hF, 5'b00001, 3'd1, 20'hFFFFF});
    chk(arr_erase_req && arr_erase_sector == 3'd3, "R8 no restart while busy",
        {29'b0, arr_erase_sector}, 32'd3);
    csr_read(1'b1, rd);
    chk(rd == 32'hF0FFFFFF, "R8 R3 wp stored while busy", rd, 32'hF0FFFFFF);
    pulse_done();
    chk(dp_waitreq == 1'b0, "R11 no stall in idle", {31'b0, dp_waitreq}, 32'd0);
    dp_cmd = 1'b0;
    csr_read(1'b0, rd);
    chk(rd[4] == 1'b1, "R5 erase ok", {31'b0, rd[4]}, 32'd1);

    // R4: status write has no effect
    csr_write(1'b0, 32'h0000_0000);
    chk(arr_erase_req == 1'b0, "R4 no launch from status write", {31'b0, arr_erase_req}, 32'd0);
    csr_read(1'b0, rd);
    exp_stat = {22'h3FFFFF, HIDE, 5'b10000};
    chk(rd == exp_stat, "R4 status unchanged", rd, exp_stat);

    // R13 and R8: data-path activity
    dp_wr_active = 1'b1;
    csr_read(1'b0, rd);
    chk(rd[1:0] == 2'b10, "R13 busy programming", {30'b0, rd[1:0]}, 32'd2);
    csr_write(1'b1, {4'hF, 5'b00000, 3'd3, 20'hFFFFF});
    chk(arr_erase_req == 1'b0, "R8 refused while programming", {31'b0, arr_erase_req}, 32'd0);
    dp_wr_active = 1'b0; dp_rd_active = 1'b1;
    csr_read(1'b0, rd);
    chk(rd[1:0] == 2'b11, "R13 busy reading", {30'b0, rd[1:0]}, 32'd3);
    dp_rd_active = 1'b0;
    @(negedge clk); dp_rd_done = 1'b1; dp_rd_ok = 1'b1; dp_wr_done = 1'b1; dp_wr_ok = 1'b0;
    @(negedge clk); dp_rd_done = 1'b0; dp_wr_done = 1'b0;
    csr_read(1'b0, rd);
    chk(rd[3:2] == 2'b01, "R13 result bits", {30'b0, rd[3:2]}, 32'd1);
    @(negedge clk); dp_wr_done = 1'b1; dp_wr_ok = 1'b1;
    @(negedge clk); dp_wr_done = 1'b0;
    csr_read(1'b0, rd);
    chk(rd[3:2] == 2'b11, "R13 program ok", {30'b0, rd[3:2]}, 32'd3);

    // R12: timeout without done
    csr_write(1'b1, {4'hF, 5'b00000, 3'd4, 20'hFFFFF});
    chk(arr_erase_req == 1'b1, "R12 launched", {31'b0, arr_erase_req}, 32'd1);
    repeat (MAXC - 2) @(negedge clk);
    chk(arr_erase_req == 1'b1, "R12 held to limit", {31'b0, arr_erase_req}, 32'd1);
    repeat (2) @(negedge clk);
    chk(arr_erase_req == 1'b0, "R12 dropped after limit", {31'b0, arr_erase_req}, 32'd0);
    csr_read(1'b0, rd);
    chk(rd[4] == 1'b0 && rd[1:0] == 2'b00, "R12 erase failed", {27'b0, rd[4:0]}, 32'd12);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule